// File: doc/BRIEF.md
# Partial-Word Merge Unit

This unit carries out the four byte-merging transfers that a little-endian 32-bit core uses for unaligned word data. The two load variants read an aligned memory word and place some of its bytes into the destination register. The register bytes that are not replaced keep their value. The two store variants read the aligned memory word, replace some of its bytes with bytes from the source register, and write the word back.

Which bytes move, and to which lanes, depends on the two low address bits. The memory access itself always uses the word-aligned address.

A request is taken in one cycle while the unit is idle. The unit then owns the memory port for a short fixed sequence:
- a load uses one read cycle, then a one-cycle result pulse;
- a store uses one read cycle, then one write cycle.

The caller supplies the architectural register value. It can also supply a pending load result that has not yet been committed, and that result then takes its place.

Top module: `partial_word_merger`

## Requirements
- R1: Every memory read or write presents the request address with its two low bits forced to zero. Every offset 0 to 3 is accepted and none raises an error.
- R2: Load-left (op code 2'b00) with offset k gives `(reg & M) | (mem << S)`, where for k=0,1,2,3 the mask M is 00FFFFFF, 0000FFFF, 000000FF, 00000000 and the shift S is 24, 16, 8, 0.
- R3: Load-right (op code 2'b01) with offset k gives `(reg & M) | (mem >> S)`, where M is 00000000, FF000000, FFFF0000, FFFFFF00 and S is 0, 8, 16, 24.
- R4: Store-left (op code 2'b10) with offset k writes `(mem & M) | (reg >> S)`, where M is FFFFFF00, FFFF0000, FF000000, 00000000 and S is 24, 16, 8, 0.
- R5: Store-right (op code 2'b11) with offset k writes `(mem & M) | (reg << S)`, where M is 00000000, 000000FF, 0000FFFF, 00FFFFFF and S is 0, 8, 16, 24.
- R6: When `fwd_valid_i` is high together with an accepted request, `fwd_data_i` is used as the register value in place of `reg_val_i`.
- R7: For a load accepted at clock edge N:
  - `mem_rd_o` is high in the cycle that follows edge N;
  - `load_valid_o` is high for exactly one cycle after edge N+1, with the merged value on `load_data_o`.
- R8: A store accepted at edge N reads in the cycle after edge N. It writes the merged word in the cycle after edge N+1, and never reads and writes in the same cycle.
- R9: `busy_o` is high from the cycle after acceptance through the last cycle of the sequence. A request presented while `busy_o` is high is ignored.
- R10: After reset, `busy_o`, `mem_rd_o`, `mem_wr_o` and `load_valid_o` are low, and `load_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_op_i | input | 2 | Op code: bit 1 selects store, bit 0 selects right |
| req_addr_i | input | ADDR_W | Byte address |
| reg_val_i | input | 32 | Committed register value (destination for loads, source for stores) |
| fwd_valid_i | input | 1 | Pending load result is valid |
| fwd_data_i | input | 32 | Pending load result for the same register |
| busy_o | output | 1 | Sequence in progress |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_addr_o | output | ADDR_W | Word-aligned memory address |
| mem_rdata_i | input | 32 | Read data, valid in the cycle `mem_rd_o` is high |
| mem_wdata_o | output | 32 | Merged store word |
| load_valid_o | output | 1 | One-cycle load result strobe |
| load_data_o | output | 32 | Merged load result |

## Verification
The bench sweeps every op code against every offset, using several data patterns whose bytes are all distinct.

Offsets 0 and 3 are the boundary cases. At one of them a variant moves the whole word and keeps nothing, and at the other it moves a single byte. A lane selector that is off by one moves the wrong byte or one byte too many. A mask and a shift that are swapped between the left and right variants also show up directly.

Forwarded data is driven with a committed value that differs from it, so a design that ignores the bypass returns the stale bytes.

A conflicting request is held high during a store. A design that accepts it would produce a spurious load pulse or overwrite the stored word.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic [1:0] {
    OP_LDL = 2'b00,
    OP_LDR = 2'b01,
    OP_STL = 2'b10,
    OP_STR = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_READ  = 2'b01,
    ST_WRITE = 2'b10
  } state_e;
endpackage

// File: rtl/pwm_lane_merge.sv
module pwm_lane_merge
  import pwm_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int OFS_W  = $clog2(LANES),
  localparam int WORD_W = LANES * BYTE_W
) (
  input  op_e               op_i,
  input  logic [OFS_W-1:0]  ofs_i,
  input  logic [WORD_W-1:0] reg_i,
  input  logic [WORD_W-1:0] mem_i,
  output logic [WORD_W-1:0] res_o
);
  localparam int TOP = LANES - 1;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [BYTE_W-1:0] lane;
    always_comb begin
      int k;
      k = int'(ofs_i);
      lane = reg_i[i*BYTE_W +: BYTE_W];
      unique case (op_i)
        // left load: top k+1 lanes come from memory low bytes
        OP_LDL: if (i >= TOP - k) lane = mem_i[(i - (TOP - k))*BYTE_W +: BYTE_W];
        // right load: low lanes come from memory starting at byte k
        OP_LDR: if (i <= TOP - k) lane = mem_i[(i + k)*BYTE_W +: BYTE_W];
        // left store: low k+1 lanes come from register high bytes
        OP_STL: lane = (i <= k) ? reg_i[(i + TOP - k)*BYTE_W +: BYTE_W]
                                : mem_i[i*BYTE_W +: BYTE_W];
        // right store: lanes from k upward come from register low bytes
        OP_STR: lane = (i >= k) ? reg_i[(i - k)*BYTE_W +: BYTE_W]
                                : mem_i[i*BYTE_W +: BYTE_W];
        default: lane = reg_i[i*BYTE_W +: BYTE_W];
      endcase
    end
    assign res_o[i*BYTE_W +: BYTE_W] = lane;
  end
endmodule

// File: rtl/pwm_ctrl.sv
module pwm_ctrl
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int OFS_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  op_e               req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] reg_val_i,
  input  logic              fwd_valid_i,
  input  logic [WORD_W-1:0] fwd_data_i,
  output state_e            state_o,
  output op_e               op_o,
  output logic [OFS_W-1:0]  ofs_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [WORD_W-1:0] regv_o
);
  state_e state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      op_o    <= OP_LDL;
      ofs_o   <= '0;
      addr_o  <= '0;
      regv_o  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          state_q <= ST_READ;
          op_o    <= req_op_i;
          ofs_o   <= req_addr_i[OFS_W-1:0];
          addr_o  <= {req_addr_i[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
          regv_o  <= fwd_valid_i ? fwd_data_i : reg_val_i;
        end
        ST_READ:  state_q <= op_o[1] ? ST_WRITE : ST_IDLE;
        ST_WRITE: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/partial_word_merger.sv
module partial_word_merger
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int WORD_W = LANES * BYTE_W,
  localparam int OFS_W  = $clog2(LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        req_op_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] reg_val_i,
  input  logic              fwd_valid_i,
  input  logic [WORD_W-1:0] fwd_data_i,
  output logic              busy_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic [WORD_W-1:0] mem_wdata_o,
  output logic              load_valid_o,
  output logic [WORD_W-1:0] load_data_o
);
  state_e            state;
  op_e               op_q;
  logic [OFS_W-1:0]  ofs_q;
  logic [WORD_W-1:0] regv_q;
  logic [WORD_W-1:0] merged;
  logic [WORD_W-1:0] wdata_q;

  pwm_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFS_W(OFS_W)) i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_op_i    (op_e'(req_op_i)),
    .req_addr_i  (req_addr_i),
    .reg_val_i   (reg_val_i),
    .fwd_valid_i (fwd_valid_i),
    .fwd_data_i  (fwd_data_i),
    .state_o     (state),
    .op_o        (op_q),
    .ofs_o       (ofs_q),
    .addr_o      (mem_addr_o),
    .regv_o      (regv_q)
  );

  pwm_lane_merge #(.LANES(LANES), .BYTE_W(BYTE_W)) i_merge (
    .op_i  (op_q),
    .ofs_i (ofs_q),
    .reg_i (regv_q),
    .mem_i (mem_rdata_i),
    .res_o (merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_valid_o <= 1'b0;
      load_data_o  <= '0;
      wdata_q      <= '0;
    end else begin
      load_valid_o <= (state == ST_READ) && !op_q[1];
      if (state == ST_READ && !op_q[1]) load_data_o <= merged;
      if (state == ST_READ &&  op_q[1]) wdata_q     <= merged;
    end
  end

  assign busy_o      = (state != ST_IDLE);
  assign mem_rd_o    = (state == ST_READ);
  assign mem_wr_o    = (state == ST_WRITE);
  assign mem_wdata_o = wdata_q;
endmodule

// File: rtl/pwm_checker.sv
module pwm_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_o,
  input logic              mem_rd_o,
  input logic              mem_wr_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              load_valid_o
);
  p_aligned_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> (mem_addr_o[1:0] == 2'b00));

  p_read_then_result_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (mem_wr_o || load_valid_o));

  p_load_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_o |=> !load_valid_o);

  p_write_after_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |-> $past(mem_rd_o));

  p_no_rd_wr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));

  p_busy_cover_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rd_o || mem_wr_o) |-> busy_o);

  p_busy_ends_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_o |-> !busy_o);
endmodule

bind partial_word_merger pwm_checker #(.ADDR_W(ADDR_W)) i_pwm_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .busy_o       (busy_o),
  .mem_rd_o     (mem_rd_o),
  .mem_wr_o     (mem_wr_o),
  .mem_addr_o   (mem_addr_o),
  .load_valid_o (load_valid_o)
);

// File: tb/test_partial_word_merger.sv
module test_partial_word_merger;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int WATCHDOG   = 20000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [1:0]        req_op = 2'b00;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [31:0]       reg_val = '0;
  logic              fwd_valid = 1'b0;
  logic [31:0]       fwd_data = '0;
  logic              busy, mem_rd, mem_wr, load_valid;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_rdata, mem_wdata, load_data;
  logic [31:0]       mem [4];

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  partial_word_merger #(.ADDR_W(ADDR_W)) i_partial_word_merger (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_op_i(req_op),
    .req_addr_i(req_addr), .reg_val_i(reg_val), .fwd_valid_i(fwd_valid),
    .fwd_data_i(fwd_data), .busy_o(busy), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .mem_addr_o(mem_addr), .mem_rdata_i(mem_rdata), .mem_wdata_o(mem_wdata),
    .load_valid_o(load_valid), .load_data_o(load_data)
  );

  assign mem_rdata = mem[mem_addr[3:2]];
  always @(posedge clk) if (mem_wr) mem[mem_addr[3:2]] <= mem_wdata;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expect_val(input logic [1:0] op, input int k,
                                             input logic [31:0] r, input logic [31:0] m);
    logic [31:0] msk;
    int sh;
    sh = 8 * (3 - k);
    unique case (op)
      2'b00: begin msk = 32'h00FFFFFF >> (8*k); return (r & msk) | (m << sh); end
      2'b01: begin msk = ~(32'hFFFFFFFF >> (8*k)); return (r & msk) | (m >> (8*k)); end
      2'b10: begin msk = 32'hFFFFFF00 << (8*k); return (m & msk) | (r >> sh); end
      default: begin msk = ~(32'hFFFFFFFF << (8*k)); return (m & msk) | (r << (8*k)); end
    endcase
  endfunction

  function automatic string tag(input logic [1:0] op);
    unique case (op)
      2'b00: return "R2 load-left";
      2'b01: return "R3 load-right";
      2'b10: return "R4 store-left";
      default: return "R5 store-right";
    endcase
  endfunction

  task automatic run_op(input logic [1:0] op, input logic [ADDR_W-1:0] addr,
                        input logic [31:0] rv, input bit fv, input logic [31:0] fd,
                        input bit intrude);
    logic [31:0] src, old_mem, exp;
    int k, w;
    k = int'(addr[1:0]);
    w = int'(addr[3:2]);
    src = fv ? fd : rv;
    old_mem = mem[w];
    exp = expect_val(op, k, src, old_mem);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_addr = addr;
    reg_val = rv; fwd_valid = fv; fwd_data = fd;
    @(negedge clk);
    if (intrude) begin
      req_op = 2'b00; req_addr = addr ^ 32'h4; reg_val = 32'h0BAD0BAD; fwd_valid = 1'b0;
    end else begin
      req_valid = 1'b0;
    end
    // R7 R8: read cycle follows acceptance, address aligned (R1)
    check("R7/R8 read strobe", {31'b0, mem_rd}, 32'd1);
    check("R1 aligned address", mem_addr, {addr[ADDR_W-1:2], 2'b00});
    check("R9 busy during read", {31'b0, busy}, 32'd1);
    @(negedge clk);
    if (!op[1]) begin
      check("R7 load pulse", {31'b0, load_valid}, 32'd1);
      check(fv ? "R6 forwarded load" : tag(op), load_data, exp);
      check("R9 busy cleared", {31'b0, busy}, 32'd0);
    end else begin
      check("R8 write strobe", {31'b0, mem_wr}, 32'd1);
      check(fv ? "R6 forwarded store" : tag(op), mem_wdata, exp);
      check("R8 no load pulse on store", {31'b0, load_valid}, 32'd0);
      @(negedge clk);
      req_valid = 1'b0;
      check("R9 busy cleared", {31'b0, busy}, 32'd0);
      check("R9 intruding request ignored", {31'b0, load_valid}, 32'd0);
      check(tag(op), mem[w], exp);
    end
    @(negedge clk);
    check("R7 single pulse", {31'b0, load_valid}, 32'd0);
  endtask

  initial begin
    mem[0] = 32'h11223344; mem[1] = 32'h55667788;
    mem[2] = 32'h99AABBCC; mem[3] = 32'hDDEEFF00;
    #(CLK_PERIOD*2 + 2);
    // R10: reset state
    check("R10 busy", {31'b0, busy}, 32'd0);
    check("R10 rd/wr", {30'b0, mem_rd, mem_wr}, 32'd0);
    check("R10 load_valid", {31'b0, load_valid}, 32'd0);
    check("R10 load_data", load_data, 32'd0);
    rst_n = 1'b1;
    for (int pat = 0; pat < 3; pat++) begin
      for (int op = 0; op < 4; op++) begin
        for (int k = 0; k < 4; k++) begin
          logic [ADDR_W-1:0] a;
          logic [31:0] rv, fd;
          a  = ADDR_W'((op * 4 + k + pat) % 16) & 32'hC;
          a  = a | ADDR_W'(k) | 32'h8000_0000;
          rv = 32'hA1B2C3D4 ^ (32'h01010101 * (pat + 1)) ^ (32'h10 * op);
          fd = 32'hE5F60718 + 32'h04030201 * k;
          run_op(2'(op), a, rv, pat == 2, fd, 1'b0);
        end
      end
    end
    // R9: requests held during a store are ignored
    run_op(2'b10, 32'h0000_0005, 32'hCAFEF00D, 1'b0, 32'h0, 1'b1);
    run_op(2'b11, 32'h0000_000A, 32'h87654321, 1'b0, 32'h0, 1'b1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule